// File: doc/BRIEF.md
# Finite-Field Power-Sum Unit

This block evaluates `y = C + A·B²` over GF(2^M) in a single combinational pass. All three operands and the result are M-bit field elements in polynomial basis: bit n holds the coefficient of x^n. The field is defined by a monic generating polynomial of degree M. Its low M coefficients arrive on a port at run time, and the x^M coefficient is implied. The polynomial need not be irreducible, so the block computes the same residue for any modulus of that shape.

The datapath has two stages. The first is a power-sum stage. It spreads B onto even degrees to form its square without multipliers. It then forms every partial product of A with that square and sums each output degree in a balanced XOR tree, which gives the unreduced 3M−2 coefficient product. The second stage folds each coefficient of degree M and above back into the low M positions, using precomputed residues of x^(M+t). Each output bit is a second balanced XOR tree, and that tree also takes in the matching bit of C.

A build option swaps the run-time residue table for constants derived from x^M + x + 1. Synthesis then removes most of the fold logic, and the polynomial port is no longer used. Typical uses are syndrome and key-equation datapaths in algebraic decoders, where `C + A·B²` is a recurring step.

Top module: `gf_power_sum`

## Requirements
- R1: With TRINOMIAL=0, `y_o` equals `c_i` XOR (`a_i` · `b_i` · `b_i` mod P), where P = x^M + Σ poly_i[k]·x^k and all values are polynomial-basis vectors with bit n the coefficient of x^n.
- R2: Any value of `poly_i` is accepted, including non-irreducible values and zero. With `poly_i` = 0 the result is `c_i` XOR the low M coefficients of A·B².
- R3: If `a_i` or `b_i` is zero, `y_o` equals `c_i`.
- R4: If `b_i` is 1 (the unit element), `y_o` equals `c_i` XOR `a_i`.
- R5: If M ≥ 3, `a_i` = 1 and `b_i` = 2 (the element x), then `y_o` equals `c_i` XOR 4 (the element x²).
- R6: If `a_i` = x^(M−1), `b_i` = x, and the effective polynomial has bit M−1 clear, then `y_o` equals `c_i` XOR (effective polynomial shifted left one place, truncated to M bits). The effective polynomial is `poly_i`, or 3 when TRINOMIAL=1.
- R7: The highest product degree, x^(3M−3), reached with `a_i` = `b_i` = x^(M−1), reduces to the correct residue for every polynomial.
- R8: With TRINOMIAL=1, `poly_i` has no effect and the result equals R1 evaluated with P = x^M + x + 1.
- R9: The same function holds for every M from 2 to 64, including M = 4 and M = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | M | Multiplicand A |
| b_i | input | M | Element B, squared inside the block |
| c_i | input | M | Addend C |
| poly_i | input | M | Low M coefficients of the generating polynomial (ignored when TRINOMIAL=1) |
| y_o | output | M | Result C + A·B² mod P |

## Verification
The bench targets the product's top degree (A = B = x^(M−1)). A fold table that is one row short, or that misses the final shift, corrupts only that corner and the residues next to it. Polynomials with bit M−1 set exercise the conditional re-fold inside the residue table. A table that drops this step reduces x^(M+1) wrongly while still passing the easy cases. The zero polynomial and a non-irreducible polynomial show whether the block assumes a particular field: with modulus x^M, a design that kept any high coefficient would leak bits into the result. In trinomial builds the bench drives random values on the polynomial port, so a build that still reads it gives results that change with that port.

// File: rtl/gfps_pkg.sv
package gfps_pkg;

   // Widest field the block is built for.
   localparam int unsigned GFPS_MAX_M = 64;

   // Low coefficients of x^M + x + 1.
   localparam logic [GFPS_MAX_M-1:0] GFPS_TRI_LOW = 64'h3;

   // Number of coefficients of an unreduced A * B^2 (degrees 0 .. 3M-3).
   function automatic int prod_width(input int m);
      return 3 * m - 2;
   endfunction

   // Number of product coefficients above degree M-1 that need folding.
   function automatic int fold_rows(input int m);
      return 2 * m - 2;
   endfunction

   // Smallest i with b_i contributing to degree k (k = j + 2i, j < m).
   function automatic int lo_idx(input int m, input int k);
      int v;
      v = k - (m - 1);
      if (v < 0) v = 0;
      return (v + 1) / 2;
   endfunction

   // Largest i with b_i contributing to degree k.
   function automatic int hi_idx(input int m, input int k);
      int v;
      v = k / 2;
      if (v > m - 1) v = m - 1;
      return v;
   endfunction

   function automatic int term_count(input int m, input int k);
      return hi_idx(m, k) - lo_idx(m, k) + 1;
   endfunction

endpackage

// File: rtl/gfps_xor_tree.sv
// Balanced parity tree over N input bits; depth ceil(log2 N).
module gfps_xor_tree #(
   parameter int N = 4
) (
   input  logic [N-1:0] bits_i,
   output logic         x_o
);
   localparam int LVL = (N > 1) ? $clog2(N) : 0;
   localparam int P   = 1 << LVL;

   if (N < 1) begin : g_bad_n
      $error("gfps_xor_tree: N must be at least 1");
   end

   for (genvar l = 0; l <= LVL; l++) begin : g_lvl
      logic [(P >> l)-1:0] v;
      if (l == 0) begin : g_leaf
         always_comb begin
            v = '0;
            v[N-1:0] = bits_i;
         end
      end else begin : g_node
         for (genvar i = 0; i < (P >> l); i++) begin : g_pair
            assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
         end
      end
   end

   assign x_o = g_lvl[LVL].v[0];
endmodule

// File: rtl/gfps_power_sum.sv
// Unreduced A * B^2. B^2 places b_i at degree 2i, so degree k sums
// a_j & b_i over all j + 2i = k. Each degree is one balanced tree.
module gfps_power_sum import gfps_pkg::*; #(
   parameter int M = 8
) (
   input  logic [M-1:0]              a_i,
   input  logic [M-1:0]              b_i,
   output logic [prod_width(M)-1:0]  d_o
);
   localparam int W = prod_width(M);

   for (genvar k = 0; k < W; k++) begin : g_deg
      localparam int LO = lo_idx(M, k);
      localparam int NT = term_count(M, k);
      logic [NT-1:0] term;
      for (genvar q = 0; q < NT; q++) begin : g_term
         assign term[q] = a_i[k - 2*(LO + q)] & b_i[LO + q];
      end
      gfps_xor_tree #(.N(NT)) u_tree (
         .bits_i (term),
         .x_o    (d_o[k])
      );
   end
endmodule

// File: rtl/gfps_fold_table.sv
// Residues r_t = x^(M+t) mod P for t = 0 .. 2M-3, packed row by row.
// The trinomial variant ties the source polynomial to a constant.
module gfps_fold_table import gfps_pkg::*; #(
   parameter int M         = 8,
   parameter bit TRINOMIAL = 1'b0
) (
   input  logic [M-1:0]                 poly_i,
   output logic [fold_rows(M)*M-1:0]    fold_o
);
   localparam int NHI = fold_rows(M);

   logic [M-1:0] gsrc;
   logic [M-1:0] row [NHI];

   if (TRINOMIAL) begin : g_tri
      localparam logic [M-1:0] GCONST = GFPS_TRI_LOW[M-1:0];
      assign gsrc = GCONST;
   end else begin : g_gen
      assign gsrc = poly_i;
   end

   assign row[0] = gsrc;
   for (genvar t = 1; t < NHI; t++) begin : g_row
      // x * r_{t-1}; an overflow into x^M re-folds as gsrc.
      assign row[t] = {row[t-1][M-2:0], 1'b0} ^ ({M{row[t-1][M-1]}} & gsrc);
   end

   for (genvar t = 0; t < NHI; t++) begin : g_pack
      assign fold_o[t*M +: M] = row[t];
   end
endmodule

// File: rtl/gfps_reduce.sv
// Folds the high product coefficients back through the residue table
// and adds C in the same tree.
module gfps_reduce import gfps_pkg::*; #(
   parameter int M = 8
) (
   input  logic [prod_width(M)-1:0]   d_i,
   input  logic [fold_rows(M)*M-1:0]  fold_i,
   input  logic [M-1:0]               c_i,
   output logic [M-1:0]               y_o
);
   localparam int NHI = fold_rows(M);
   localparam int NT  = NHI + 2;

   for (genvar n = 0; n < M; n++) begin : g_bit
      logic [NT-1:0] term;
      for (genvar t = 0; t < NHI; t++) begin : g_hi
         assign term[t] = d_i[M + t] & fold_i[t*M + n];
      end
      assign term[NHI]     = d_i[n];
      assign term[NHI + 1] = c_i[n];
      gfps_xor_tree #(.N(NT)) u_tree (
         .bits_i (term),
         .x_o    (y_o[n])
      );
   end
endmodule

// File: rtl/gf_power_sum.sv
module gf_power_sum import gfps_pkg::*; #(
   parameter int M         = 8,
   parameter bit TRINOMIAL = 1'b0
) (
   input  logic [M-1:0] a_i,
   input  logic [M-1:0] b_i,
   input  logic [M-1:0] c_i,
   input  logic [M-1:0] poly_i,
   output logic [M-1:0] y_o
);
   localparam int W   = prod_width(M);
   localparam int NHI = fold_rows(M);

   if (M < 2 || M > GFPS_MAX_M) begin : g_bad_m
      $error("gf_power_sum: M must lie in 2..64");
   end

   logic [W-1:0]     prod;
   logic [NHI*M-1:0] fold;

   gfps_power_sum #(.M(M)) u_ps (
      .a_i (a_i),
      .b_i (b_i),
      .d_o (prod)
   );

   gfps_fold_table #(.M(M), .TRINOMIAL(TRINOMIAL)) u_tab (
      .poly_i (poly_i),
      .fold_o (fold)
   );

   gfps_reduce #(.M(M)) u_red (
      .d_i    (prod),
      .fold_i (fold),
      .c_i    (c_i),
      .y_o    (y_o)
   );
endmodule

// File: rtl/gf_power_sum_chk.sv
module gf_power_sum_chk import gfps_pkg::*; #(
   parameter int M         = 8,
   parameter bit TRINOMIAL = 1'b0
) (
   input logic [M-1:0] a_i,
   input logic [M-1:0] b_i,
   input logic [M-1:0] c_i,
   input logic [M-1:0] poly_i,
   input logic [M-1:0] y_o
);
   localparam logic [M-1:0] ONE  = 1;
   localparam logic [M-1:0] XEL  = ONE << 1;
   localparam logic [M-1:0] XTOP = ONE << (M - 1);

   logic [M-1:0] g_eff;
   assign g_eff = TRINOMIAL ? GFPS_TRI_LOW[M-1:0] : poly_i;

   always_comb begin
      if (a_i == '0 || b_i == '0) begin
         p_zero_operand_r3: assert (y_o == c_i)
            else $error("R3: zero operand must pass C through");
      end
      if (b_i == ONE) begin
         p_unit_square_r4: assert (y_o == (c_i ^ a_i))
            else $error("R4: B=1 must give C^A");
      end
      if (a_i == XTOP && b_i == XEL && !g_eff[M-1]) begin
         p_single_fold_r6: assert (y_o == (c_i ^ {g_eff[M-2:0], 1'b0}))
            else $error("R6: x^(M+1) fold mismatch");
      end
   end

   if (M >= 3) begin : g_sq
      always_comb begin
         if (a_i == ONE && b_i == XEL) begin
            p_x_squared_r5: assert (y_o == (c_i ^ (ONE << 2)))
               else $error("R5: x squared mismatch");
         end
      end
   end
endmodule

bind gf_power_sum gf_power_sum_chk #(.M(M), .TRINOMIAL(TRINOMIAL)) u_chk (.*);

// File: tb/gf_power_sum_test.sv
module gf_power_sum_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // unit 0: M=8 general, unit 1: M=4 general, unit 2: M=8 trinomial
   logic [7:0] a8 = '0, b8 = '0, c8 = '0, g8 = '0, y8;
   logic [3:0] a4 = '0, b4 = '0, c4 = '0, g4 = '0, y4;
   logic [7:0] at = '0, bt = '0, ct = '0, gt = '0, yt;

   gf_power_sum #(.M(8), .TRINOMIAL(1'b0)) uut (
      .a_i(a8), .b_i(b8), .c_i(c8), .poly_i(g8), .y_o(y8));
   gf_power_sum #(.M(4), .TRINOMIAL(1'b0)) uut_m4 (
      .a_i(a4), .b_i(b4), .c_i(c4), .poly_i(g4), .y_o(y4));
   gf_power_sum #(.M(8), .TRINOMIAL(1'b1)) uut_tri (
      .a_i(at), .b_i(bt), .c_i(ct), .poly_i(gt), .y_o(yt));

   typedef struct {
      int          unit;
      logic [63:0] exp;
      string       req;
   } item_t;
   item_t sb[$];

   // Shift-and-reduce multiply modulo x^m + g.
   function automatic logic [63:0] gmul(int m, logic [63:0] g,
                                        logic [63:0] a, logic [63:0] b);
      logic [63:0] acc, sh, mask;
      logic        carry;
      mask = (m == 64) ? '1 : ((64'd1 << m) - 1);
      acc  = '0;
      sh   = a & mask;
      for (int i = 0; i < m; i++) begin
         if (b[i]) acc ^= sh;
         carry = sh[m-1];
         sh    = (sh << 1) & mask;
         if (carry) sh ^= (g & mask);
      end
      return acc;
   endfunction

   function automatic logic [63:0] ref_ps(int m, logic [63:0] g, logic [63:0] a,
                                          logic [63:0] b, logic [63:0] c);
      return c ^ gmul(m, g, a, gmul(m, g, b, b));
   endfunction

   task automatic drive(int unit, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                        logic [63:0] g, logic [63:0] exp, string req);
      item_t it;
      @(posedge clk);
      case (unit)
         0: begin a8 = a[7:0]; b8 = b[7:0]; c8 = c[7:0]; g8 = g[7:0]; end
         1: begin a4 = a[3:0]; b4 = b[3:0]; c4 = c[3:0]; g4 = g[3:0]; end
         default: begin at = a[7:0]; bt = b[7:0]; ct = c[7:0]; gt = g[7:0]; end
      endcase
      it.unit = unit;
      it.exp  = exp;
      it.req  = req;
      sb.push_back(it);
   endtask

   // Monitor: compare at the falling edge, one item per cycle.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [63:0] act;
         it = sb.pop_front();
         case (it.unit)
            0: act = {56'd0, y8};
            1: act = {60'd0, y4};
            default: act = {56'd0, yt};
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s unit=%0d actual=%h expected=%h", it.req, it.unit,
                     act, it.exp);
         end
      end
   end

   function automatic logic [63:0] rnd();
      return {$urandom, $urandom};
   endfunction

   initial begin
      logic [7:0] polys8 [4];
      logic [3:0] polys4 [3];
      logic [63:0] a, b, c, g;
      polys8[0] = 8'h1B; polys8[1] = 8'h1D; polys8[2] = 8'hA9; polys8[3] = 8'h63;
      polys4[0] = 4'h3;  polys4[1] = 4'h9;  polys4[2] = 4'hF;

      // Idle state: all-zero inputs give zero (R3)
      drive(0, 0, 0, 0, 0, 0, "R3");

      // R1: random operands under several polynomials, M=8
      for (int p = 0; p < 4; p++) begin
         for (int n = 0; n < 150; n++) begin
            a = rnd() & 8'hFF; b = rnd() & 8'hFF; c = rnd() & 8'hFF;
            drive(0, a, b, c, polys8[p], ref_ps(8, polys8[p], a, b, c), "R1");
         end
      end

      // R9: M=4 field
      for (int p = 0; p < 3; p++) begin
         for (int n = 0; n < 100; n++) begin
            a = rnd() & 4'hF; b = rnd() & 4'hF; c = rnd() & 4'hF;
            drive(1, a, b, c, polys4[p], ref_ps(4, polys4[p], a, b, c), "R9");
         end
      end

      // R2: zero polynomial, all-ones polynomial, random polynomial
      for (int n = 0; n < 40; n++) begin
         a = rnd() & 8'hFF; b = rnd() & 8'hFF; c = rnd() & 8'hFF;
         drive(0, a, b, c, 0, ref_ps(8, 0, a, b, c), "R2");
         drive(0, a, b, c, 8'hFF, ref_ps(8, 8'hFF, a, b, c), "R2");
         g = rnd() & 8'hFF;
         drive(0, a, b, c, g, ref_ps(8, g, a, b, c), "R2");
      end

      // R3: either operand zero gives C
      for (int n = 0; n < 20; n++) begin
         b = rnd() & 8'hFF; c = rnd() & 8'hFF; g = rnd() & 8'hFF;
         drive(0, 0, b, c, g, c, "R3");
         drive(0, b, 0, c, g, c, "R3");
      end

      // R4: B=1 gives C^A
      for (int n = 0; n < 20; n++) begin
         a = rnd() & 8'hFF; c = rnd() & 8'hFF; g = rnd() & 8'hFF;
         drive(0, a, 1, c, g, c ^ a, "R4");
         drive(1, a & 4'hF, 1, c & 4'hF, g & 4'hF, (c ^ a) & 4'hF, "R4");
      end

      // R5: A=1, B=x gives C ^ x^2
      for (int n = 0; n < 10; n++) begin
         c = rnd() & 8'hFF; g = rnd() & 8'hFF;
         drive(0, 1, 2, c, g, c ^ 4, "R5");
         drive(1, 1, 2, c & 4'hF, g & 4'hF, (c & 4'hF) ^ 4, "R5");
      end

      // R6: A=x^(M-1), B=x, g bit M-1 clear gives C ^ (g<<1)
      for (int n = 0; n < 20; n++) begin
         c = rnd() & 8'hFF; g = rnd() & 8'h7F;
         drive(0, 8'h80, 2, c, g, c ^ ((g << 1) & 8'hFF), "R6");
         drive(1, 4'h8, 2, c & 4'hF, g & 4'h7, (c & 4'hF) ^ ((g << 1) & 4'hF), "R6");
      end

      // R7: top degree x^(3M-3)
      for (int p = 0; p < 4; p++) begin
         drive(0, 8'h80, 8'h80, 0, polys8[p], ref_ps(8, polys8[p], 8'h80, 8'h80, 0), "R7");
         drive(0, 8'hFF, 8'hFF, 8'hFF, polys8[p],
               ref_ps(8, polys8[p], 8'hFF, 8'hFF, 8'hFF), "R7");
      end
      for (int p = 0; p < 3; p++) begin
         drive(1, 4'h8, 4'h8, 0, polys4[p], ref_ps(4, polys4[p], 4'h8, 4'h8, 0), "R7");
      end

      // R8: trinomial build ignores the polynomial port
      for (int n = 0; n < 100; n++) begin
         a = rnd() & 8'hFF; b = rnd() & 8'hFF; c = rnd() & 8'hFF; g = rnd() & 8'hFF;
         drive(2, a, b, c, g, ref_ps(8, 3, a, b, c), "R8");
      end
      drive(2, 8'h80, 8'h80, 8'h00, 8'hFF, ref_ps(8, 3, 8'h80, 8'h80, 0), "R8");
      drive(2, 8'h80, 2, 8'h00, 8'h5A, 8'h06, "R8");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule